// File: doc/BRIEF.md
# Single-Digit Stopwatch Core with Lap Capture and Alarm

This block keeps one decimal seconds digit. The digit advances once per second from a fast system clock and is shown on a seven-segment display. Two raw push buttons control it: start/pause and lap. A shift-register filter cleans up each button, and only the moment a press is accepted turns into a request. A serial command decoder elsewhere on the chip can send one-cycle strobes for start/pause, lap and a soft clear. These strobes have the same effect as the buttons.

A lap request stores the digit on screen in a 4-bit lap output. That output holds until the next lap request. A 4-bit target from switches is compared with the digit. The decimal point stays lit for as long as the two are equal. On each entry into equality, a one-cycle event goes out to a telemetry transmitter.

All pins are plain control and status lines. The command strobes and the alarm event are single-cycle pulses without valid/ready handshakes. The block cannot stall a command, and the event is not held for a slow consumer. A consumer that needs back-pressure has to register the event itself.

Top module: `stopwatch_core`

## Requirements
- R1: After the active-low reset `rst_n` is released, all of the following hold:
  - the digit, the lap output and the run state are 0;
  - the prescaler count is 0;
  - `alarm_evt` is low.
- R2: While running, the digit advances by one every `TICKS_PER_SEC` clock cycles and wraps from 9 to 0. With the default parameters this is 1 Hz from 10 MHz.
- R3: A start/pause request toggles the run state. While stopped, the digit and the prescaler count hold their values.
- R4: A raw button input is accepted only after `DEBOUNCE_LEN` consecutive identical samples. The accepted level rising from 0 to 1 produces exactly one request. Bursts shorter than that produce none.
- R5: `cmd_start` and `cmd_lap` act exactly like an accepted start or lap press, taking effect on the next clock edge.
- R6: A lap request copies the digit as it stood before that edge into `lap_digit`. `lap_digit` holds until the next lap request or clear.
- R7: `cmd_clear` sets the digit, `lap_digit`, the run state and the prescaler count to 0 on the next edge. It takes priority over every other request in the same cycle.
- R8: `seg_out[6:0]` is active high, with segment a on bit 0 through segment g on bit 6. Digits 0 to 9 encode as 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R9: `seg_out[7]` is high exactly while the digit equals `alarm_target`.
- R10: `alarm_evt` is high for one cycle when the digit and `alarm_target` become equal after being unequal in the previous cycle. It does not fire for a match that already holds when reset is released.
- R11: A button release, meaning the accepted level falling from 1 to 0, produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_start_raw | input | 1 | Raw start/pause push button, high when pressed |
| btn_lap_raw | input | 1 | Raw lap push button, high when pressed |
| cmd_start | input | 1 | One-cycle start/pause command strobe |
| cmd_lap | input | 1 | One-cycle lap command strobe |
| cmd_clear | input | 1 | One-cycle soft clear strobe |
| alarm_target | input | 4 | Alarm comparison value from switches |
| seg_out | output | 8 | Segments a..g on bits 0..6, decimal point (alarm match) on bit 7 |
| lap_digit | output | 4 | Digit captured by the last lap request |
| alarm_evt | output | 1 | One-cycle pulse on entry into alarm equality |

## Verification
Some properties are checked on every cycle:
- each prescaler tick steps the digit modulo ten;
- a stopped digit stays constant;
- every start request flips the run state;
- a lap request loads the previous digit, and `lap_digit` is otherwise stable;
- a clear zeroes the state;
- an alarm event never lasts two cycles and always coincides with a lit decimal point.

Other behaviour only the bench's scenarios can show, using a per-clock behavioural model:
- bounce bursts are rejected;
- a release gives no request;
- the display encoding is correct;
- one full ten-second cycle yields exactly one alarm event.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int DIGIT_W = 4;
  localparam int LAST_DIGIT = 9;
  localparam int SEG_W = 7;
  localparam int NUM_BTN = 2;
  localparam int BTN_START = 0;
  localparam int BTN_LAP = 1;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/sw_debounce.sv
module sw_debounce #(
  parameter int DEBOUNCE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic press
);
  logic [DEBOUNCE_LEN-1:0] hist_q;
  logic [DEBOUNCE_LEN-1:0] hist_nxt;
  logic level_q;

  assign hist_nxt = {hist_q[DEBOUNCE_LEN-2:0], raw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      level_q <= 1'b0;
      press   <= 1'b0;
    end else begin
      hist_q <= hist_nxt;
      press  <= 1'b0;
      if ((&hist_nxt) && !level_q) begin
        level_q <= 1'b1;
        press   <= 1'b1;
      end else if (!(|hist_nxt) && level_q) begin
        level_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
  parameter int TICKS_PER_SEC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sw_seg_decode.sv
module sw_seg_decode
  import stopwatch_pkg::*;
(
  input  digit_t digit,
  output seg_t   segs
);
  always_comb begin
    unique case (digit)
      4'd0: segs = 7'h3F;
      4'd1: segs = 7'h06;
      4'd2: segs = 7'h5B;
      4'd3: segs = 7'h4F;
      4'd4: segs = 7'h66;
      4'd5: segs = 7'h6D;
      4'd6: segs = 7'h7D;
      4'd7: segs = 7'h07;
      4'd8: segs = 7'h7F;
      4'd9: segs = 7'h6F;
      default: segs = 7'h00;
    endcase
  end
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
  import stopwatch_pkg::*;
#(
  parameter int TICKS_PER_SEC = 10_000_000,
  parameter int DEBOUNCE_LEN  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_start_raw,
  input  logic       btn_lap_raw,
  input  logic       cmd_start,
  input  logic       cmd_lap,
  input  logic       cmd_clear,
  input  logic [3:0] alarm_target,
  output logic [7:0] seg_out,
  output logic [3:0] lap_digit,
  output logic       alarm_evt
);
  logic [NUM_BTN-1:0] btn_raw;
  logic [NUM_BTN-1:0] btn_press;
  logic   start_req;
  logic   lap_req;
  logic   tick;
  logic   run_q;
  digit_t digit_q;
  logic   match;
  logic   match_q;
  seg_t   segs;

  assign btn_raw[BTN_START] = btn_start_raw;
  assign btn_raw[BTN_LAP]   = btn_lap_raw;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    sw_debounce #(.DEBOUNCE_LEN(DEBOUNCE_LEN)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (btn_raw[b]),
      .press (btn_press[b])
    );
  end

  assign start_req = btn_press[BTN_START] | cmd_start;
  assign lap_req   = btn_press[BTN_LAP]   | cmd_lap;

  sw_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cmd_clear),
    .run   (run_q),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      digit_q   <= '0;
      lap_digit <= '0;
    end else if (cmd_clear) begin
      run_q     <= 1'b0;
      digit_q   <= '0;
      lap_digit <= '0;
    end else begin
      run_q <= run_q ^ start_req;
      if (lap_req) lap_digit <= digit_q;
      if (tick) digit_q <= (digit_q == DIGIT_W'(LAST_DIGIT)) ? '0 : digit_q + 1'b1;
    end
  end

  assign match = (digit_q == alarm_target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b1;
    else        match_q <= match;
  end

  assign alarm_evt = match && !match_q;

  sw_seg_decode u_dec (
    .digit (digit_q),
    .segs  (segs)
  );

  assign seg_out = {match, segs};
endmodule

// File: rtl/stopwatch_core_chk.sv
module stopwatch_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_clear,
  input logic [3:0] alarm_target,
  input logic [7:0] seg_out,
  input logic [3:0] lap_digit,
  input logic       alarm_evt,
  input logic [3:0] digit_q,
  input logic       run_q,
  input logic       start_req,
  input logic       lap_req,
  input logic       tick
);
  assert_digit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    digit_q <= 4'd9);

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cmd_clear) |=>
      digit_q == (($past(digit_q) == 4'd9) ? 4'd0 : $past(digit_q) + 4'd1));

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd_clear) |=> $stable(digit_q));

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !cmd_clear) |=> (run_q != $past(run_q)));

  assert_lap_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lap_req && !cmd_clear) |=> (lap_digit == $past(digit_q)));

  assert_lap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lap_req && !cmd_clear) |=> $stable(lap_digit));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (digit_q == 4'd0 && lap_digit == 4'd0 && !run_q));

  assert_evt_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> !alarm_evt);

  assert_evt_lit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> (seg_out[7] && digit_q == alarm_target));
endmodule

bind stopwatch_core stopwatch_core_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_clear    (cmd_clear),
  .alarm_target (alarm_target),
  .seg_out      (seg_out),
  .lap_digit    (lap_digit),
  .alarm_evt    (alarm_evt),
  .digit_q      (digit_q),
  .run_q        (run_q),
  .start_req    (start_req),
  .lap_req      (lap_req),
  .tick         (tick)
);

// File: tb/stopwatch_core_bench.sv
module stopwatch_core_bench;
  localparam int TPS = 20;
  localparam int DBL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_start_raw = 1'b0;
  logic btn_lap_raw = 1'b0;
  logic cmd_start = 1'b0;
  logic cmd_lap = 1'b0;
  logic cmd_clear = 1'b0;
  logic [3:0] alarm_target = 4'd0;
  logic [7:0] seg_out;
  logic [3:0] lap_digit;
  logic alarm_evt;

  int n_checks = 0;
  int n_fails = 0;
  int evt_count = 0;
  bit count_evt = 1'b0;

  always #10 clk = ~clk;

  stopwatch_core #(.TICKS_PER_SEC(TPS), .DEBOUNCE_LEN(DBL)) u_stopwatch_core (
    .clk(clk), .rst_n(rst_n), .btn_start_raw(btn_start_raw), .btn_lap_raw(btn_lap_raw),
    .cmd_start(cmd_start), .cmd_lap(cmd_lap), .cmd_clear(cmd_clear),
    .alarm_target(alarm_target), .seg_out(seg_out), .lap_digit(lap_digit),
    .alarm_evt(alarm_evt)
  );

  // Behavioural reference model
  int m_digit, m_lap, m_cnt;
  bit m_run, m_mprev;
  int m_last[2], m_same[2];
  bit m_deb[2], m_pulse[2];

  function automatic int seg_of(int d);
    case (d)
      0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F; 4: return 'h66;
      5: return 'h6D; 6: return 'h7D; 7: return 'h07; 8: return 'h7F; 9: return 'h6F;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_digit = 0; m_lap = 0; m_cnt = 0; m_run = 0; m_mprev = 1;
      for (int b = 0; b < 2; b++) begin
        m_last[b] = 0; m_same[b] = DBL; m_deb[b] = 0; m_pulse[b] = 0;
      end
    end else begin
      bit sreq, lreq, tk;
      int raw;
      sreq = m_pulse[0] | cmd_start;
      lreq = m_pulse[1] | cmd_lap;
      tk = m_run && (m_cnt == TPS - 1);
      m_mprev = (m_digit == alarm_target);
      if (cmd_clear) begin
        m_digit = 0; m_lap = 0; m_run = 0; m_cnt = 0;
      end else begin
        if (lreq) m_lap = m_digit;
        if (m_run) m_cnt = (m_cnt == TPS - 1) ? 0 : m_cnt + 1;
        if (tk) m_digit = (m_digit + 1) % 10;
        m_run = m_run ^ sreq;
      end
      for (int b = 0; b < 2; b++) begin
        raw = (b == 0) ? btn_start_raw : btn_lap_raw;
        if (raw == m_last[b]) begin
          if (m_same[b] < DBL) m_same[b]++;
        end else begin
          m_last[b] = raw; m_same[b] = 1;
        end
        m_pulse[b] = 0;
        if (m_same[b] >= DBL && m_deb[b] != raw) begin
          m_deb[b] = raw[0];
          m_pulse[b] = raw[0];
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8 segments", int'(seg_out[6:0]), seg_of(m_digit));
      check("R9 decimal point", int'(seg_out[7]), int'(m_digit == alarm_target));
      check("R6 lap output", int'(lap_digit), m_lap);
      check("R10 alarm event", int'(alarm_evt), int'((m_digit == alarm_target) && !m_mprev));
      if (count_evt && alarm_evt) evt_count++;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic strobe(ref logic sig);
    sig = 1'b1;
    step(1);
    sig = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(3);
    // R1: cleared state, digit 0 matches target 0
    check("R1 reset display", int'(seg_out), 'hBF);
    check("R1 reset lap", int'(lap_digit), 0);
    check("R1 reset event", int'(alarm_evt), 0);

    // R5 / R2: command strobe starts counting; digit 3 during cycles 60..79
    strobe(cmd_start);
    step(65);
    check("R2 R5 digit after three periods", int'(seg_out), 'h4F);
    step(180);
    check("R2 wrap to digit 2", int'(seg_out), 'h5B);

    // R3: pause holds the digit
    strobe(cmd_start);
    step(100);
    check("R3 paused digit holds", int'(seg_out), 'h5B);

    // R6 / R5: lap via command
    strobe(cmd_lap);
    check("R6 lap via command", int'(lap_digit), 2);

    // R7: soft clear
    strobe(cmd_clear);
    check("R7 clear display", int'(seg_out), 'hBF);
    check("R7 clear lap", int'(lap_digit), 0);

    // R4: bounce bursts shorter than the filter give no request
    for (int i = 0; i < 6; i++) begin
      btn_start_raw = 1'b1; step(5);
      btn_start_raw = 1'b0; step(5);
    end
    step(40);
    check("R4 bounce rejected", int'(seg_out), 'hBF);

    // R4 / R11: clean press starts, release must not pause
    btn_start_raw = 1'b1;
    step(12);
    btn_start_raw = 1'b0;
    step(33);
    check("R4 R11 press starts, release ignored", int'(seg_out), 'h06);

    // R6: lap via button, captured while digit is 2
    btn_lap_raw = 1'b1;
    step(10);
    btn_lap_raw = 1'b0;
    step(5);
    check("R6 lap via button", int'(lap_digit), 2);

    // R10 / R9: exactly one event per ten-second cycle
    alarm_target = 4'd5;
    step(2);
    evt_count = 0;
    count_evt = 1'b1;
    step(10 * TPS);
    count_evt = 1'b0;
    check("R10 one event per cycle", evt_count, 1);

    // R10: target change into equality while stopped fires an event
    strobe(cmd_start);
    step(3);
    alarm_target = lap_digit;
    step(5);
    alarm_target = 4'd9;
    step(5);
    step(20);
    finish_run();
  end
endmodule